// File: doc/BRIEF.md
# Stateful Memory Access Policy Checker

This block is a hardware reference monitor for a shared memory bus. For every request it receives the identity of the requesting module, a two-bit operation code and an address. It returns one registered verdict, grant or deny, marked by a one-cycle valid pulse. The address is compared with every configured range at the same time. Each range is an address prefix whose low-order bits are don't-care. The result is a small range ID.

The requester ID, the operation and the range ID together form one access descriptor. That descriptor is the only input to a two-state policy automaton. The automaton's current state selects a permission table, and certain granted writes move it from one state to the other. As a result, one module's permission on a shared range can be withdrawn and later restored while the system runs. The range patterns, both permission tables and the two trigger descriptors are fixed at elaboration through parameters.

Top module: `mpc_access_monitor`

## Requirements
- R1: While `rst` is high, `req_ready` and `dec_valid` are low and requests are ignored. The automaton leaves reset in its base state, and `req_ready` rises within two cycles after reset is released.
- R2: A request is accepted when `req_valid` and `req_ready` are both high at a rising edge. If it is presented in cycle c, `dec_valid` is high in cycle c+2 only, with `dec_grant` holding the verdict. `dec_grant` is never high without `dec_valid`.
- R3: Range k matches when the address agrees with the k-th pattern on every bit set in the k-th care mask. The matched range's ID is k+1. The default ranges are ID 1 for 0x1000–0x1FFF, ID 2 for 0x2000–0x2FFF, and ID 3 for 0x2000–0x3FFF.
- R4: When several ranges match, the lowest ID wins. For example, 0x2500 resolves to ID 2.
- R5: An address matching no range gets ID 0, and every access with ID 0 is denied.
- R6: Operation bit 0 requests read and bit 1 requests write. Code 11 needs both rights, and code 00 is always denied.
- R7: In the base state, module 1 may read and write range 1 and read range 3. Module 2 may read and write range 2 and read range 3. Module 3 may read and write range 3. Module 0 and every other combination are denied.
- R8: In the alternate state, module 2 has no access to range 3. All other rights are the same as in the base state.
- R9: A granted access with the write bit set, from module 3 to range 3, moves the automaton from the base state to the alternate state.
- R10: A granted access with the write bit set, from module 1 to range 1, moves the automaton from the alternate state back to the base state.
- R11: A denied access never changes the automaton state.
- R12: A request accepted in the cycle right after a state-changing request is judged under the new state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Monitor can accept a request |
| req_module | input | MOD_W | Requesting module ID |
| req_op | input | 2 | Operation: bit 0 read, bit 1 write |
| req_addr | input | ADDR_W | Request address |
| dec_valid | output | 1 | Verdict valid pulse |
| dec_grant | output | 1 | 1 grants, 0 denies the access |

## Verification
Two things can happen in the same cycle. The policy stage can commit a state change for one request while the matching stage is registering the descriptor of the next one. The bench provokes this with two pairs of requests sent back to back. The first pair is module 3 writing range 3 followed at once by module 2 reading range 3, which must be denied. The second pair is module 1 writing range 1 followed at once by the same read, which must be granted again. Reset arriving while requests are being driven is the second collision. It is judged by an absent verdict pulse and by a read that the base state must grant after reset.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

  // Operation code layout
  localparam int OP_W      = 2;
  localparam int OP_RD_BIT = 0;
  localparam int OP_WR_BIT = 1;

  // Policy automaton states; the value selects the permission table slice
  typedef enum logic {
    POL_BASE = 1'b0,
    POL_ALT  = 1'b1
  } pol_state_e;

  localparam int NUM_POL_STATES = 2;

endpackage

// File: rtl/mpc_range_match.sv
module mpc_range_match #(
  parameter int ADDR_W     = 16,
  parameter int NUM_RANGES = 3,
  parameter int RID_W      = 2,
  parameter logic [NUM_RANGES-1:0][ADDR_W-1:0] PATTERN = '0,
  parameter logic [NUM_RANGES-1:0][ADDR_W-1:0] CARE    = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [RID_W-1:0]  rid
);

  logic [NUM_RANGES-1:0] hit;

  // All ranges are compared at the same time, each against its own masked prefix
  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_cmp
    assign hit[g] = (((addr ^ PATTERN[g]) & CARE[g]) == '0);
  end

  // Priority pick: the scan runs downward, so the lowest-numbered hit is written last and wins
  always_comb begin
    rid = '0;
    for (int i = NUM_RANGES - 1; i >= 0; i--) begin
      if (hit[i]) rid = RID_W'(i + 1);
    end
  end

endmodule

// File: rtl/mpc_policy_fsm.sv
module mpc_policy_fsm
  import mpc_pkg::*;
#(
  parameter int MOD_W    = 2,
  parameter int RID_W    = 2,
  parameter int NUM_RIDS = 4,
  parameter logic [NUM_POL_STATES*(2**MOD_W)*NUM_RIDS*OP_W-1:0] POLICY = '0,
  parameter int ARM_MOD  = 3,
  parameter int ARM_RID  = 3,
  parameter int REL_MOD  = 1,
  parameter int REL_RID  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [MOD_W-1:0] in_mod,
  input  logic [OP_W-1:0]  in_op,
  input  logic [RID_W-1:0] in_rid,
  output logic             dec_valid,
  output logic             dec_grant
);

  localparam int NUM_MODS = 2 ** MOD_W;
  localparam int POL_BITS = NUM_POL_STATES * NUM_MODS * NUM_RIDS * OP_W;
  localparam int SEL_W    = $clog2(POL_BITS);

  pol_state_e       state_q, state_d;
  logic [SEL_W-1:0] base;
  logic [OP_W-1:0]  perm;
  logic             legal;
  logic             arm_hit, rel_hit;

  // Table entry index: ((state * modules + module) * range_ids + range_id) * op_width
  always_comb begin
    base = SEL_W'(((int'(state_q) * NUM_MODS + int'(in_mod)) * NUM_RIDS + int'(in_rid)) * OP_W);
    perm = POLICY[base +: OP_W];
  end

  assign legal   = (in_rid != '0) && (in_op != '0) && ((in_op & ~perm) == '0);
  assign arm_hit = (in_mod == MOD_W'(ARM_MOD)) && (in_rid == RID_W'(ARM_RID));
  assign rel_hit = (in_mod == MOD_W'(REL_MOD)) && (in_rid == RID_W'(REL_RID));

  always_comb begin
    state_d = state_q;
    if (in_valid && legal && in_op[OP_WR_BIT]) begin
      if (state_q == POL_BASE && arm_hit) state_d = POL_ALT;
      else if (state_q == POL_ALT && rel_hit) state_d = POL_BASE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= POL_BASE;
      dec_valid <= 1'b0;
      dec_grant <= 1'b0;
    end else begin
      state_q   <= state_d;
      dec_valid <= in_valid;
      dec_grant <= in_valid && legal;
    end
  end

  // R5: a descriptor without a range is always refused
  assert_norange_deny_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_rid == '0) |=> (dec_valid && !dec_grant));

  // R11: a refused verdict leaves the automaton where it was
  assert_hold_on_deny_R11: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !dec_grant) |-> $stable(state_q));

  // R9: entering the alternate state is caused only by a granted arming descriptor
  assert_arm_cause_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == POL_ALT && $past(state_q) == POL_BASE && !$past(rst)) |->
      (dec_grant && $past(in_mod) == MOD_W'(ARM_MOD) && $past(in_rid) == RID_W'(ARM_RID)
       && $past(in_op[OP_WR_BIT])));

  // R10: returning to the base state is caused only by a granted release descriptor
  assert_release_cause_R10: assert property (@(posedge clk) disable iff (rst)
    (state_q == POL_BASE && $past(state_q) == POL_ALT && !$past(rst)) |->
      (dec_grant && $past(in_mod) == MOD_W'(REL_MOD) && $past(in_rid) == RID_W'(REL_RID)
       && $past(in_op[OP_WR_BIT])));

  // R2: no grant without a verdict strobe
  assert_grant_needs_valid_R2: assert property (@(posedge clk) disable iff (rst)
    dec_grant |-> dec_valid);

endmodule

// File: rtl/mpc_access_monitor.sv
module mpc_access_monitor
  import mpc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int MOD_W      = 2,
  parameter int NUM_RANGES = 3,
  // Range k has ID k+1; index 0 is the rightmost entry
  parameter logic [NUM_RANGES-1:0][ADDR_W-1:0] RANGE_PATTERN = {16'h2000, 16'h2000, 16'h1000},
  parameter logic [NUM_RANGES-1:0][ADDR_W-1:0] RANGE_CARE    = {16'hE000, 16'hF000, 16'hF000},
  // Two 32-bit slices, alternate state in the upper slice; within a slice, byte m is module m
  // and bit pair r of that byte is {write, read} for range ID r
  parameter logic [NUM_POL_STATES*(2**MOD_W)*(NUM_RANGES+1)*OP_W-1:0] POLICY =
    64'hC0304C00_C0704C00,
  parameter int ARM_MOD   = 3,
  parameter int ARM_RANGE = 3,
  parameter int REL_MOD   = 1,
  parameter int REL_RANGE = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [MOD_W-1:0]  req_module,
  input  logic [OP_W-1:0]   req_op,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              dec_valid,
  output logic              dec_grant
);

  localparam int NUM_RIDS = NUM_RANGES + 1;
  localparam int RID_W    = $clog2(NUM_RIDS);

  logic             ready_q;
  logic             accept;
  logic [RID_W-1:0] match_rid;

  logic             s1_valid;
  logic [MOD_W-1:0] s1_mod;
  logic [OP_W-1:0]  s1_op;
  logic [RID_W-1:0] s1_rid;

  assign req_ready = ready_q;
  assign accept    = req_valid && ready_q && !rst;

  always_ff @(posedge clk) begin
    if (rst) ready_q <= 1'b0;
    else     ready_q <= 1'b1;
  end

  mpc_range_match #(
    .ADDR_W     (ADDR_W),
    .NUM_RANGES (NUM_RANGES),
    .RID_W      (RID_W),
    .PATTERN    (RANGE_PATTERN),
    .CARE       (RANGE_CARE)
  ) u_match (
    .addr (req_addr),
    .rid  (match_rid)
  );

  // Stage 1: registered access descriptor
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_mod   <= '0;
      s1_op    <= '0;
      s1_rid   <= '0;
    end else begin
      s1_valid <= accept;
      if (accept) begin
        s1_mod <= req_module;
        s1_op  <= req_op;
        s1_rid <= match_rid;
      end
    end
  end

  // Stage 2: policy automaton and registered verdict
  mpc_policy_fsm #(
    .MOD_W    (MOD_W),
    .RID_W    (RID_W),
    .NUM_RIDS (NUM_RIDS),
    .POLICY   (POLICY),
    .ARM_MOD  (ARM_MOD),
    .ARM_RID  (ARM_RANGE),
    .REL_MOD  (REL_MOD),
    .REL_RID  (REL_RANGE)
  ) u_policy (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (s1_valid),
    .in_mod    (s1_mod),
    .in_op     (s1_op),
    .in_rid    (s1_rid),
    .dec_valid (dec_valid),
    .dec_grant (dec_grant)
  );

  // R1: reset closes the request port and clears the verdict strobe
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!req_ready && !dec_valid));

  // R2: every accepted request yields a verdict two cycles after it was presented
  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    accept |=> ##1 dec_valid);

  // R3: a matched range ID never exceeds the number of configured ranges
  assert_rid_bound_R3: assert property (@(posedge clk) disable iff (rst)
    s1_valid |-> (int'(s1_rid) <= NUM_RANGES));

endmodule

// File: tb/test_mpc_access_monitor.sv
module test_mpc_access_monitor;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int MW = 2;
  localparam int NV = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [MW-1:0] req_module = '0;
  logic [1:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic          dec_valid;
  logic          dec_grant;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mpc_access_monitor i_mpc_access_monitor (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_module (req_module),
    .req_op     (req_op),
    .req_addr   (req_addr),
    .dec_valid  (dec_valid),
    .dec_grant  (dec_grant)
  );

  // Each entry is {module, op, address, expected grant}; the vectors are applied in order
  localparam logic [20:0] VEC [NV] = '{
    {2'd1, 2'b01, 16'h1234, 1'b1},  // 0  R7  m1 read r1
    {2'd1, 2'b10, 16'h1FFF, 1'b1},  // 1  R7  m1 write r1
    {2'd1, 2'b01, 16'h3000, 1'b1},  // 2  R7  m1 read r3
    {2'd1, 2'b10, 16'h3000, 1'b0},  // 3  R7  m1 write r3 denied
    {2'd2, 2'b11, 16'h2500, 1'b1},  // 4  R4  overlap resolves to r2
    {2'd2, 2'b01, 16'h3F00, 1'b1},  // 5  R3  top of r3 masked prefix
    {2'd2, 2'b01, 16'h1000, 1'b0},  // 6  R7  m2 on r1 denied
    {2'd1, 2'b01, 16'h4000, 1'b0},  // 7  R5  no range
    {2'd0, 2'b01, 16'h1000, 1'b0},  // 8  R7  module 0 has nothing
    {2'd1, 2'b00, 16'h1000, 1'b0},  // 9  R6  empty op
    {2'd3, 2'b10, 16'h1000, 1'b0},  // 10 R11 denied write by m3
    {2'd2, 2'b01, 16'h3000, 1'b1},  // 11 R11 state unchanged
    {2'd3, 2'b10, 16'h3456, 1'b1},  // 12 R9  arm
    {2'd2, 2'b01, 16'h3000, 1'b0},  // 13 R8  read revoked
    {2'd2, 2'b10, 16'h2000, 1'b1},  // 14 R8  m2 keeps r2
    {2'd1, 2'b01, 16'h3000, 1'b1},  // 15 R8  m1 keeps r3 read
    {2'd3, 2'b11, 16'h3000, 1'b1},  // 16 R8  m3 read/write in alt state
    {2'd1, 2'b10, 16'h1000, 1'b1},  // 17 R10 release
    {2'd2, 2'b01, 16'h3000, 1'b1},  // 18 R10 read restored
    {2'd2, 2'b10, 16'h3000, 1'b0}   // 19 R6  write not permitted
  };

  function automatic string vec_tag(input int i);
    case (i)
      3'd4:     return "R4";
      5:        return "R3";
      7:        return "R5";
      9, 19:    return "R6";
      10, 11:   return "R11";
      12:       return "R9";
      13, 14, 15, 16: return "R8";
      17, 18:   return "R10";
      default:  return "R7";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Presents one request for one cycle; returns at the falling edge after acceptance
  task automatic send(input logic [MW-1:0] m, input logic [1:0] op, input logic [AW-1:0] a);
    @(negedge clk);
    req_valid  = 1'b1;
    req_module = m;
    req_op     = op;
    req_addr   = a;
    @(negedge clk);
    req_valid  = 1'b0;
  endtask

  task automatic expect_verdict(input bit exp, input string tag);
    check(dec_valid == 1'b0, "R2 early", int'(dec_valid), 0);
    @(negedge clk);
    check(dec_valid == 1'b1, "R2 pulse", int'(dec_valid), 1);
    check(dec_grant == exp, tag, int'(dec_grant), int'(exp));
    @(negedge clk);
    check(dec_valid == 1'b0, "R2 single pulse", int'(dec_valid), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R2 watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: requests driven during reset are ignored
    req_valid  = 1'b1;
    req_module = 2'd1;
    req_op     = 2'b01;
    req_addr   = 16'h1000;
    repeat (3) begin
      @(negedge clk);
      check(req_ready == 1'b0, "R1 ready in reset", int'(req_ready), 0);
      check(dec_valid == 1'b0, "R1 verdict in reset", int'(dec_valid), 0);
    end
    rst       = 1'b0;
    req_valid = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check(dec_valid == 1'b0, "R1 no verdict after reset", int'(dec_valid), 0);
    end
    check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][20:19], VEC[i][18:17], VEC[i][16:1]);
      expect_verdict(VEC[i][0], vec_tag(i));
    end

    // R12: back to back, arming write then the revoked read
    @(negedge clk);
    req_valid = 1'b1; req_module = 2'd3; req_op = 2'b10; req_addr = 16'h3000;
    @(negedge clk);
    check(dec_valid == 1'b0, "R12 early", int'(dec_valid), 0);
    req_module = 2'd2; req_op = 2'b01; req_addr = 16'h3000;
    @(negedge clk);
    req_valid = 1'b0;
    check(dec_valid && dec_grant, "R12 arming write granted", int'(dec_grant), 1);
    @(negedge clk);
    check(dec_valid == 1'b1, "R12 second verdict", int'(dec_valid), 1);
    check(dec_grant == 1'b0, "R12 read under new state", int'(dec_grant), 0);

    // R12: back to back, release write then the restored read
    @(negedge clk);
    req_valid = 1'b1; req_module = 2'd1; req_op = 2'b10; req_addr = 16'h1800;
    @(negedge clk);
    req_module = 2'd2; req_op = 2'b01; req_addr = 16'h3000;
    @(negedge clk);
    req_valid = 1'b0;
    check(dec_valid && dec_grant, "R12 release write granted", int'(dec_grant), 1);
    @(negedge clk);
    check(dec_valid && dec_grant, "R12 read restored at once", int'(dec_grant), 1);

    // R1: reset from the alternate state returns to base; traffic during reset is dropped
    send(2'd3, 2'b10, 16'h3000);
    expect_verdict(1'b1, "R9 arm before reset");
    @(negedge clk);
    rst = 1'b1;
    req_valid = 1'b1; req_module = 2'd2; req_op = 2'b01; req_addr = 16'h3000;
    repeat (3) begin
      @(negedge clk);
      check(dec_valid == 1'b0, "R1 verdict during reset", int'(dec_valid), 0);
    end
    rst = 1'b0;
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    check(dec_valid == 1'b0, "R1 dropped request", int'(dec_valid), 0);
    send(2'd2, 2'b01, 16'h3000);
    expect_verdict(1'b1, "R1 base state after reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule